// File: doc/BRIEF.md
# Two-level interrupt request controller

This block gathers interrupt events for a small 8-bit core and turns them into a single request with a vector index. Timer modules each deliver two comparator-match pulses (an A match and a P match). The two pulses of one timer share a group vector. A serial interface delivers four kinds of event pulse, and these share one direct vector. The block holds the latched request flags, the enables for each source and for each group, and a global enable. It presents one pending, eligible interrupt to the core.

The core answers with a one-cycle acknowledge and reports when its call stack is full. On acknowledge the block clears the global enable and the flag of the vector it served. For a group vector, only the group flag is cleared. The timer source flags underneath stay set until software clears them through the byte-wide register write port. For the serial vector, the serial flag itself is cleared.

Top module: `mfint_ctrl`

## Requirements
- R1: After reset every flag, every enable and the global enable are 0, so `irq_req` stays low even once all enables are written to 1.
- R2: A timer event pulse always latches its source flag. The group flag sets when that source's enable is 1, either at the event or on the cycle the enable is written from 0 to 1 while the source flag is held.
- R3: A group vector is requested only while the global enable, the group enable and the group flag are all 1.
- R4: While `stack_full` is 1, `irq_req` is 0. The pending request reappears as soon as `stack_full` returns to 0.
- R5: `irq_ack` together with `irq_req` clears the global enable and the served group flag. The timer source flags are kept, so turning a source enable off and on again raises the request again, unless software has cleared that source flag.
- R6: Any one of the four serial event bits sets the serial flag, whatever the serial enable is. A serial request needs the global enable and the serial enable. Acknowledge clears the serial flag and the global enable.
- R7: Vector codes are: group g gives code g, and the serial vector gives code NUM_GRP. When several vectors are eligible, the lowest group index wins, and the serial vector comes last (`SER_HIGH`=0).
- R8: Register map. Address 0, bit 0 is the global enable. Address 1: bit 0 is the serial enable, and writing 1 to bit 7 clears the serial flag. Address 2+g: bit 0 is the group enable, bit 1 is the A enable and bit 2 is the P enable; writing 1 to bit 5 clears the A flag, to bit 6 clears the P flag, and to bit 7 clears the group flag. Enable bits take the written value.
- R9: When a hardware event sets a flag in the same cycle that software clears it, the flag stays set.
- R10: `irq_ack` while `irq_req` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tm_a_evt | input | NUM_GRP | Comparator A match pulse, one per timer |
| tm_p_evt | input | NUM_GRP | Comparator P match pulse, one per timer |
| ser_evt | input | 4 | Serial event pulses: received, transmitted, address match, time-out |
| reg_addr | input | ADDR_W | Register write address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| stack_full | input | 1 | Core call stack full |
| irq_ack | input | 1 | One-cycle service acknowledge |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VW | Vector code of the request |

## Verification
Event pulses and register writes act on the clock edge that samples them. Their effect on `irq_req` and `irq_vec` is therefore due right after that single edge, and the bench samples one time unit after the edge. `stack_full` reaches `irq_req` through logic alone, so the bench checks it a moment after the input changes, with no edge in between. An acknowledge removes the request at the edge that samples it. Each directed task starts from a fresh reset, so every expected value follows from that task's own stimulus.

// File: rtl/mfint_pkg.sv
package mfint_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_EMI = 0;
  localparam int unsigned ADDR_SER = 1;
  localparam int unsigned ADDR_GRP = 2;
  // bit positions in the write data
  localparam int unsigned B_EMI   = 0;
  localparam int unsigned B_SIME  = 0;
  localparam int unsigned B_SCLR  = 7;
  localparam int unsigned B_MFE   = 0;
  localparam int unsigned B_ENA   = 1;
  localparam int unsigned B_ENP   = 2;
  localparam int unsigned B_CLRA  = 5;
  localparam int unsigned B_CLRP  = 6;
  localparam int unsigned B_CLRMF = 7;

  typedef struct packed {
    logic mfe;
    logic ena;
    logic enp;
    logic clr_a;
    logic clr_p;
    logic clr_mf;
  } grp_wr_t;
endpackage

// File: rtl/mfint_grp.sv
module mfint_grp
  import mfint_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ev_a,
  input  logic    ev_p,
  input  logic    wr,
  input  grp_wr_t cfg,
  input  logic    ack_clr,
  output logic    req
);
  logic ena_q, enp_q, mfe_q, fa_q, fp_q, mf_q;
  logic ena_n, enp_n, fa_n, fp_n, mf_n, rise_a, rise_p;

  always_comb begin
    ena_n  = wr ? cfg.ena : ena_q;
    enp_n  = wr ? cfg.enp : enp_q;
    // hardware event beats the software clear
    fa_n   = ev_a | (fa_q & ~(wr & cfg.clr_a));
    fp_n   = ev_p | (fp_q & ~(wr & cfg.clr_p));
    rise_a = ena_n & (ev_a | (fa_n & ~(fa_q & ena_q)));
    rise_p = enp_n & (ev_p | (fp_n & ~(fp_q & enp_q)));
    mf_n   = rise_a | rise_p | (mf_q & ~(wr & cfg.clr_mf) & ~ack_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= 1'b0;
      enp_q <= 1'b0;
      mfe_q <= 1'b0;
      fa_q  <= 1'b0;
      fp_q  <= 1'b0;
      mf_q  <= 1'b0;
    end else begin
      if (wr) begin
        ena_q <= ena_n;
        enp_q <= enp_n;
        mfe_q <= cfg.mfe;
      end
      fa_q <= fa_n;
      fp_q <= fp_n;
      mf_q <= mf_n;
    end
  end

  assign req = mfe_q & mf_q;
endmodule

// File: rtl/mfint_ser.sv
module mfint_ser #(
  parameter int unsigned NUM_EV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev,
  input  logic              wr,
  input  logic              en_d,
  input  logic              clr,
  input  logic              ack_clr,
  output logic              req
);
  logic en_q, flag_q, flag_n;

  always_comb begin
    flag_n = (|ev) | (flag_q & ~(wr & clr) & ~ack_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr) en_q <= en_d;
      flag_q <= flag_n;
    end
  end

  assign req = en_q & flag_q;
endmodule

// File: rtl/mfint_arb.sv
module mfint_arb #(
  parameter int unsigned NUM_GRP  = 2,
  parameter bit          SER_HIGH = 1'b0,
  parameter int unsigned VW       = 2
) (
  input  logic [NUM_GRP-1:0] grp_req,
  input  logic               ser_req,
  output logic               any,
  output logic [VW-1:0]      vec
);
  localparam logic [VW-1:0] SER_VEC = VW'(NUM_GRP);

  always_comb begin
    any = 1'b0;
    vec = '0;
    if (SER_HIGH && ser_req) begin
      any = 1'b1;
      vec = SER_VEC;
    end else begin
      for (int g = NUM_GRP - 1; g >= 0; g--) begin
        if (grp_req[g]) begin
          any = 1'b1;
          vec = VW'(g);
        end
      end
      if (!any && ser_req) begin
        any = 1'b1;
        vec = SER_VEC;
      end
    end
  end
endmodule

// File: rtl/mfint_ctrl.sv
module mfint_ctrl
  import mfint_pkg::*;
#(
  parameter int unsigned NUM_GRP  = 2,
  parameter int unsigned ADDR_W   = 4,
  parameter bit          SER_HIGH = 1'b0,
  localparam int unsigned VW      = $clog2(NUM_GRP + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GRP-1:0] tm_a_evt,
  input  logic [NUM_GRP-1:0] tm_p_evt,
  input  logic [3:0]         ser_evt,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_we,
  input  logic               stack_full,
  input  logic               irq_ack,
  output logic               irq_req,
  output logic [VW-1:0]      irq_vec
);
  localparam logic [VW-1:0] SER_VEC = VW'(NUM_GRP);

  logic [1:0]         rs_q;
  logic               rst_q;
  logic               emi_q, emi_n;
  logic               any, take;
  logic [NUM_GRP-1:0] grp_req;
  logic               ser_req, wr_emi, wr_ser;
  grp_wr_t            gcfg;
  logic               unused_wdata;

  // reset: asserted at once, removed on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  assign unused_wdata = ^reg_wdata[4:3];
  assign wr_emi = reg_we && (reg_addr == ADDR_W'(ADDR_EMI));
  assign wr_ser = reg_we && (reg_addr == ADDR_W'(ADDR_SER));

  always_comb begin
    gcfg.mfe    = reg_wdata[B_MFE];
    gcfg.ena    = reg_wdata[B_ENA];
    gcfg.enp    = reg_wdata[B_ENP];
    gcfg.clr_a  = reg_wdata[B_CLRA];
    gcfg.clr_p  = reg_wdata[B_CLRP];
    gcfg.clr_mf = reg_wdata[B_CLRMF];
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic wr_g;
    assign wr_g = reg_we && (reg_addr == ADDR_W'(ADDR_GRP + g));
    mfint_grp u_grp (
      .clk     (clk),
      .rst_n   (rst_q),
      .ev_a    (tm_a_evt[g]),
      .ev_p    (tm_p_evt[g]),
      .wr      (wr_g),
      .cfg     (gcfg),
      .ack_clr (take && (irq_vec == VW'(g))),
      .req     (grp_req[g])
    );
  end

  mfint_ser #(.NUM_EV(4)) u_ser (
    .clk     (clk),
    .rst_n   (rst_q),
    .ev      (ser_evt),
    .wr      (wr_ser),
    .en_d    (reg_wdata[B_SIME]),
    .clr     (reg_wdata[B_SCLR]),
    .ack_clr (take && (irq_vec == SER_VEC)),
    .req     (ser_req)
  );

  mfint_arb #(.NUM_GRP(NUM_GRP), .SER_HIGH(SER_HIGH), .VW(VW)) u_arb (
    .grp_req (grp_req),
    .ser_req (ser_req),
    .any     (any),
    .vec     (irq_vec)
  );

  assign irq_req = emi_q & any & ~stack_full;
  assign take    = irq_ack & irq_req;

  always_comb begin
    emi_n = emi_q;
    if (wr_emi) emi_n = reg_wdata[B_EMI];
    if (take)   emi_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) emi_q <= 1'b0;
    else        emi_q <= emi_n;
  end
endmodule

// File: rtl/mfint_ctrl_chk.sv
module mfint_ctrl_chk #(
  parameter int unsigned NUM_GRP = 2,
  parameter int unsigned VW      = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_req,
  input logic [VW-1:0] irq_vec,
  input logic          irq_ack,
  input logic          stack_full,
  input logic          reg_we,
  input logic          emi
);
  // R4
  stack_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |-> !irq_req);

  // R3
  needs_emi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> emi);

  // R5
  ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !irq_req);

  // R7
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec <= VW'(NUM_GRP)));

  // R10
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req && !reg_we) |=> $stable(emi));
endmodule

bind mfint_ctrl mfint_ctrl_chk #(.NUM_GRP(NUM_GRP), .VW(VW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_req    (irq_req),
  .irq_vec    (irq_vec),
  .irq_ack    (irq_ack),
  .stack_full (stack_full),
  .reg_we     (reg_we),
  .emi        (emi_q)
);

// File: tb/mfint_ctrl_tb.sv
module mfint_ctrl_tb;
  localparam int CLK_NS = 10;
  localparam int NG = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NG-1:0] tm_a, tm_p;
  logic [3:0]    ser;
  logic [3:0]    addr;
  logic [7:0]    wdata;
  logic          we, sfull, ack;
  logic          irq_req;
  logic [1:0]    irq_vec;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  mfint_ctrl #(.NUM_GRP(NG)) u_dut (
    .clk(clk), .rst_n(rst_n), .tm_a_evt(tm_a), .tm_p_evt(tm_p),
    .ser_evt(ser), .reg_addr(addr), .reg_wdata(wdata), .reg_we(we),
    .stack_full(sfull), .irq_ack(ack), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic exp_req, logic [1:0] exp_vec);
    total++;
    if (irq_req !== exp_req || (exp_req && irq_vec !== exp_vec)) begin
      bad++;
      $display("FAIL %s: req=%0b vec=%0d expected req=%0b vec=%0d",
               tag, irq_req, irq_vec, exp_req, exp_vec);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tm_a = '0; tm_p = '0; ser = '0; addr = '0;
    wdata = '0; we = 1'b0; sfull = 1'b0; ack = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 after reset", 1'b0, 2'd0);
    wr(4'd0, 8'h01); wr(4'd2, 8'h07); wr(4'd3, 8'h07); wr(4'd1, 8'h01);
    chk("R1 all enables no flags", 1'b0, 2'd0);
  endtask

  task automatic t_flag_enable();
    do_reset();
    wr(4'd0, 8'h01); wr(4'd2, 8'h01);
    tm_a[0] = 1'b1; tick(); tm_a[0] = 1'b0;
    chk("R2 source disabled", 1'b0, 2'd0);
    wr(4'd2, 8'h03);
    chk("R2 enable on held flag R8", 1'b1, 2'd0);
    sfull = 1'b1; #1;
    chk("R4 stack full", 1'b0, 2'd0);
    tick();
    chk("R4 still full", 1'b0, 2'd0);
    sfull = 1'b0; #1;
    chk("R4 stack free", 1'b1, 2'd0);
    do_ack();
    chk("R5 ack drops", 1'b0, 2'd0);
    wr(4'd0, 8'h01);
    chk("R5 group flag cleared", 1'b0, 2'd0);
    wr(4'd2, 8'h01); wr(4'd2, 8'h03);
    chk("R5 source flag kept", 1'b1, 2'd0);
    do_ack(); wr(4'd0, 8'h01);
    wr(4'd2, 8'h21); wr(4'd2, 8'h03);
    chk("R8 source flag cleared by write", 1'b0, 2'd0);
  endtask

  task automatic t_group_enable();
    do_reset();
    wr(4'd0, 8'h01); wr(4'd2, 8'h06);
    tm_p[0] = 1'b1; tick(); tm_p[0] = 1'b0;
    chk("R3 group disabled", 1'b0, 2'd0);
    wr(4'd2, 8'h07);
    chk("R3 group enabled", 1'b1, 2'd0);
    wr(4'd0, 8'h00);
    chk("R3 global off", 1'b0, 2'd0);
    wr(4'd0, 8'h01);
    chk("R3 global on", 1'b1, 2'd0);
  endtask

  task automatic t_serial();
    for (int i = 0; i < 4; i++) begin
      do_reset();
      wr(4'd0, 8'h01); wr(4'd1, 8'h01);
      ser[i] = 1'b1; tick(); ser[i] = 1'b0;
      chk("R6 serial event", 1'b1, 2'd2);
      do_ack();
      chk("R6 ack drops", 1'b0, 2'd2);
      wr(4'd0, 8'h01);
      chk("R6 serial flag cleared", 1'b0, 2'd2);
    end
    do_reset();
    wr(4'd0, 8'h01);
    ser[3] = 1'b1; tick(); ser[3] = 1'b0;
    chk("R6 serial disabled", 1'b0, 2'd2);
    wr(4'd1, 8'h01);
    chk("R6 flag latched while disabled", 1'b1, 2'd2);
  endtask

  task automatic t_priority();
    do_reset();
    wr(4'd2, 8'h07); wr(4'd3, 8'h07); wr(4'd1, 8'h01);
    tm_a = 2'b11; ser[0] = 1'b1; tick(); tm_a = '0; ser[0] = 1'b0;
    wr(4'd0, 8'h01);
    chk("R7 group 0 first", 1'b1, 2'd0);
    do_ack(); wr(4'd0, 8'h01);
    chk("R7 group 1 next", 1'b1, 2'd1);
    do_ack(); wr(4'd0, 8'h01);
    chk("R7 serial last", 1'b1, 2'd2);
    do_ack(); wr(4'd0, 8'h01);
    chk("R7 none left", 1'b0, 2'd0);
  endtask

  task automatic t_set_wins();
    do_reset();
    wr(4'd0, 8'h01); wr(4'd1, 8'h01);
    ser[1] = 1'b1; wr(4'd1, 8'h81); ser[1] = 1'b0;
    chk("R9 serial set beats clear", 1'b1, 2'd2);
    wr(4'd1, 8'h81);
    chk("R8 serial flag cleared by write", 1'b0, 2'd2);
    do_reset();
    wr(4'd0, 8'h01); wr(4'd3, 8'h07);
    tm_a[1] = 1'b1; wr(4'd3, 8'hA7); tm_a[1] = 1'b0;
    chk("R9 group set beats clear", 1'b1, 2'd1);
  endtask

  task automatic t_idle_ack();
    do_reset();
    wr(4'd1, 8'h01);
    ser[0] = 1'b1; tick(); ser[0] = 1'b0;
    chk("R10 no request with global off", 1'b0, 2'd2);
    do_ack();
    wr(4'd0, 8'h01);
    chk("R10 idle ack ignored", 1'b1, 2'd2);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_flag_enable();
    t_group_enable();
    t_serial();
    t_priority();
    t_set_wins();
    t_idle_ack();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule